// File: doc/BRIEF.md
# Sequential Signed Divider (16/8 and 32/16)

This block divides a signed double-width dividend by a signed single-width divisor over several clock cycles. It returns a single-width signed quotient and remainder. Byte mode takes a 16-bit dividend and an 8-bit divisor. Word mode takes a 32-bit dividend and a 16-bit divisor. The block divides the magnitudes with a restoring loop, one quotient bit per cycle. It then gives the quotient the XOR of the operand signs and gives the remainder the sign of the dividend. The quotient truncates toward zero.

The latency depends on the data:
- A zero divisor ends the operation after a short fixed time.
- Overflow is caught at one of two points. The first is before the loop starts, when the upper half of the dividend's magnitude is not below the divisor's magnitude. The second is after the loop, when the signed quotient does not fit the result width.
- In word mode, a negative dividend adds one cycle to every path except the zero-divisor path.

Latency is counted in rising edges. The edge that accepts the request is edge 1, and the latency is the number of the edge that raises `res_valid`.

Requests enter on a valid/ready pair:
- The block accepts a request on a rising edge where `req_valid` and `req_ready` are both high.
- `req_ready` is low for the whole time the block is busy. A `req_valid` held during that time is not accepted and has no effect. The caller holds the operands until the request is accepted.
- The result side takes no back-pressure. `res_valid` is a single-cycle pulse.
- The result and both flags then stay unchanged until the next request is accepted.

Top module: `sdiv_top`

## Requirements
- R1: In byte mode (`req_wide`=0), `req_dividend[15:0]` and `req_divisor[7:0]` are the operands. Higher input bits are ignored. A non-overflowing result appears in `res_quot[7:0]` and `res_rem[7:0]`, with bits 15:8 zero, after a latency of 18.
- R2: In word mode (`req_wide`=1), the operands are the full 32-bit dividend and 16-bit divisor. A non-overflowing result appears in `res_quot` and `res_rem` after a latency of 30 for a non-negative dividend and 31 for a negative dividend.
- R3: A zero divisor gives `res_divzero`=1 and `res_ovf`=0. `res_quot` holds the dividend's low half and `res_rem` its high half, zero-extended in byte mode. The latency is 3 in byte mode and 4 in word mode, whatever the dividend's sign.
- R4: When the divisor is non-zero and the upper half of |dividend| is at least |divisor|, `res_ovf`=1. The latency is 8 in byte mode, and 10 (non-negative dividend) or 11 (negative dividend) in word mode.
- R5: When the pre-check passes but the signed quotient falls outside the result range, `res_ovf`=1. The latency is 18 in byte mode, and 29 (non-negative dividend) or 30 (negative dividend) in word mode.
- R6: On overflow, `res_rem` holds the dividend's high half (zero-extended in byte mode). The contents of `res_quot` are not defined.
- R7: A quotient equal to the most negative value of the result width (-128 or -32768) is a valid result and raises no overflow.
- R8: `res_valid` is high for exactly one cycle per accepted request. The result and flags then hold until the next acceptance.
- R9: `req_ready` equals NOT `busy`. `busy` rises on the edge that accepts a request. A `req_valid` asserted while busy starts nothing and does not change the result.
- R10: After reset, `busy`=0, `req_ready`=1, `res_valid`=0, both flags are 0, and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_wide | input | 1 | 0 = 16/8 byte mode, 1 = 32/16 word mode |
| req_dividend | input | 32 | Signed dividend (byte mode uses bits 15:0) |
| req_divisor | input | 16 | Signed divisor (byte mode uses bits 7:0) |
| busy | output | 1 | Operation in progress |
| res_valid | output | 1 | One-cycle completion pulse |
| res_quot | output | 16 | Signed quotient |
| res_rem | output | 16 | Signed remainder |
| res_divzero | output | 1 | Divisor was zero |
| res_ovf | output | 1 | Quotient overflow |

## Verification
The embedded properties check the following on every cycle:
- the completion pulse lasts a single cycle;
- the two flags are never raised together;
- `busy` follows an accepted request;
- the zero-divisor latency and the byte-mode normal-path latency match the cycle counter.

Only the bench's scenarios can show the rest: correct quotient and remainder signs for each sign pairing, which overflow checkpoint fires for a given operand pair, the extra cycle for negative word-mode dividends, and that requests arriving while busy are ignored.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_ITER, S_FIX, S_WAIT} sdiv_st_t;

  // completion edges, counted from the accepting edge as 1
  localparam int LAT_B_ZERO = 3;
  localparam int LAT_B_PRE  = 8;
  localparam int LAT_B_RUN  = 18;
  localparam int LAT_W_ZERO = 4;
  localparam int LAT_W_PRE  = 10;
  localparam int LAT_W_POST = 29;
  localparam int LAT_W_RUN  = 30;
  localparam int CNT_W      = 6;
endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
  parameter int NW = 8,
  localparam int WW = 2 * NW
) (
  input  logic            wide,
  input  logic [2*WW-1:0] dvd,
  input  logic [WW-1:0]   dvs,
  output logic [WW-1:0]   hi_mag,
  output logic [WW-1:0]   lo_init,
  output logic [WW-1:0]   v_mag,
  output logic            neg_d,
  output logic            neg_q,
  output logic            zero,
  output logic            pre_ovf
);
  logic [2*WW-1:0] d_s, d_m;
  logic [WW-1:0]   v_s;

  always_comb begin
    d_s     = wide ? dvd : {{WW{dvd[WW-1]}}, dvd[WW-1:0]};
    v_s     = wide ? dvs : {{NW{dvs[NW-1]}}, dvs[NW-1:0]};
    neg_d   = d_s[2*WW-1];
    neg_q   = neg_d ^ v_s[WW-1];
    d_m     = neg_d ? -d_s : d_s;
    v_mag   = v_s[WW-1] ? -v_s : v_s;
    hi_mag  = wide ? d_m[2*WW-1:WW] : {{NW{1'b0}}, d_m[WW-1:NW]};
    lo_init = wide ? d_m[WW-1:0] : {d_m[NW-1:0], {NW{1'b0}}};
    zero    = (v_mag == '0);
    pre_ovf = (hi_mag >= v_mag);
  end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int WW = 16
) (
  input  logic [WW-1:0] r_in,
  input  logic          bit_in,
  input  logic [WW-1:0] v,
  output logic [WW-1:0] r_out,
  output logic          q_bit
);
  logic [WW:0] shifted, diff;

  always_comb begin
    shifted = {r_in, bit_in};
    diff    = shifted - {1'b0, v};
    q_bit   = ~diff[WW];
    r_out   = q_bit ? diff[WW-1:0] : shifted[WW-1:0];
  end
endmodule

// File: rtl/sdiv_timer.sv
module sdiv_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          load,
  input  logic [CW-1:0] target,
  output logic          fire,
  output logic [CW-1:0] count
);
  logic          armed;
  logic [CW-1:0] goal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
      goal  <= '0;
    end else begin
      count <= clear ? CW'(1) : count + 1'b1;
      if (clear) begin
        armed <= 1'b0;
      end else if (load) begin
        armed <= 1'b1;
        goal  <= target;
      end
    end
  end

  assign fire = armed && ((count + 1'b1) == goal);
endmodule

// File: rtl/sdiv_top.sv
module sdiv_top
  import sdiv_pkg::*;
#(
  parameter int NARROW_W = 8,
  localparam int WW    = 2 * NARROW_W,
  localparam int DW    = 2 * WW,
  localparam int IT_W  = $clog2(WW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_wide,
  input  logic [DW-1:0] req_dividend,
  input  logic [WW-1:0] req_divisor,
  output logic          busy,
  output logic          res_valid,
  output logic [WW-1:0] res_quot,
  output logic [WW-1:0] res_rem,
  output logic          res_divzero,
  output logic          res_ovf
);
  localparam int NW = NARROW_W;

  sdiv_st_t        st;
  logic [DW-1:0]   op_dvd;
  logic [WW-1:0]   op_dvs;
  logic            wide_r;
  logic [WW-1:0]   rem_r, sh;
  logic [IT_W-1:0] it_cnt, last_it;

  logic [WW-1:0] p_hi, p_lo, p_vmag;
  logic          p_negd, p_negq, p_zero, p_pre;
  logic [WW-1:0] s_r;
  logic          s_q;
  logic          tm_fire, tm_load, accept;
  logic [CNT_W-1:0] tm_count, tm_target;

  logic [WW-1:0] up_half, low_half, q_mag, q_sgn, r_sgn, q_out, r_out;
  logic          q_top, q_rest, post_ovf;

  sdiv_prep #(.NW(NW)) prep_i (
    .wide(wide_r), .dvd(op_dvd), .dvs(op_dvs),
    .hi_mag(p_hi), .lo_init(p_lo), .v_mag(p_vmag),
    .neg_d(p_negd), .neg_q(p_negq), .zero(p_zero), .pre_ovf(p_pre)
  );

  sdiv_step #(.WW(WW)) step_i (
    .r_in(rem_r), .bit_in(sh[WW-1]), .v(p_vmag), .r_out(s_r), .q_bit(s_q)
  );

  sdiv_timer #(.CW(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .load(tm_load),
    .target(tm_target), .fire(tm_fire), .count(tm_count)
  );

  assign busy      = (st != S_IDLE);
  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;
  assign last_it   = wide_r ? IT_W'(WW - 1) : IT_W'(NW - 1);

  always_comb begin
    up_half  = wide_r ? op_dvd[DW-1:WW] : {{NW{1'b0}}, op_dvd[WW-1:NW]};
    low_half = wide_r ? op_dvd[WW-1:0]  : {{NW{1'b0}}, op_dvd[NW-1:0]};
    q_mag    = wide_r ? sh : {{NW{1'b0}}, sh[NW-1:0]};
    q_top    = wide_r ? sh[WW-1] : sh[NW-1];
    q_rest   = wide_r ? (|sh[WW-2:0]) : (|sh[NW-2:0]);
    post_ovf = p_negq ? (q_top & q_rest) : q_top;
    q_sgn    = p_negq ? -q_mag : q_mag;
    r_sgn    = p_negd ? -rem_r : rem_r;
    q_out    = wide_r ? q_sgn : {{NW{1'b0}}, q_sgn[NW-1:0]};
    r_out    = wide_r ? r_sgn : {{NW{1'b0}}, r_sgn[NW-1:0]};
  end

  // completion target, loaded at the checkpoint that decides the path
  always_comb begin
    tm_load   = 1'b0;
    tm_target = '0;
    if (st == S_CHECK && p_zero) begin
      tm_load   = 1'b1;
      tm_target = wide_r ? CNT_W'(LAT_W_ZERO) : CNT_W'(LAT_B_ZERO);
    end else if (st == S_CHECK && p_pre) begin
      tm_load   = 1'b1;
      tm_target = wide_r ? CNT_W'(LAT_W_PRE) + CNT_W'(p_negd) : CNT_W'(LAT_B_PRE);
    end else if (st == S_FIX) begin
      tm_load   = 1'b1;
      if (!wide_r)       tm_target = CNT_W'(LAT_B_RUN);
      else if (post_ovf) tm_target = CNT_W'(LAT_W_POST) + CNT_W'(p_negd);
      else               tm_target = CNT_W'(LAT_W_RUN) + CNT_W'(p_negd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op_dvd      <= '0;
      op_dvs      <= '0;
      wide_r      <= 1'b0;
      rem_r       <= '0;
      sh          <= '0;
      it_cnt      <= '0;
      res_quot    <= '0;
      res_rem     <= '0;
      res_divzero <= 1'b0;
      res_ovf     <= 1'b0;
      res_valid   <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          op_dvd      <= req_dividend;
          op_dvs      <= req_divisor;
          wide_r      <= req_wide;
          res_divzero <= 1'b0;
          res_ovf     <= 1'b0;
          st          <= S_CHECK;
        end
        S_CHECK: begin
          if (p_zero) begin
            res_divzero <= 1'b1;
            res_quot    <= low_half;
            res_rem     <= up_half;
            st          <= S_WAIT;
          end else if (p_pre) begin
            res_ovf  <= 1'b1;
            res_quot <= p_lo;
            res_rem  <= up_half;
            st       <= S_WAIT;
          end else begin
            rem_r  <= p_hi;
            sh     <= p_lo;
            it_cnt <= '0;
            st     <= S_ITER;
          end
        end
        S_ITER: begin
          rem_r  <= s_r;
          sh     <= {sh[WW-2:0], s_q};
          it_cnt <= it_cnt + 1'b1;
          if (it_cnt == last_it) st <= S_FIX;
        end
        S_FIX: begin
          if (post_ovf) begin
            res_ovf  <= 1'b1;
            res_quot <= q_mag;
            res_rem  <= up_half;
          end else begin
            res_quot <= q_out;
            res_rem  <= r_out;
          end
          st <= S_WAIT;
        end
        S_WAIT: if (tm_fire) begin
          res_valid <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R9: an accepted request makes the block busy on the next cycle
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R3: zero-divide completion matches the short fixed latency
  a_r3_zero_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_divzero) |->
      (tm_count == (wide_r ? CNT_W'(LAT_W_ZERO) : CNT_W'(LAT_B_ZERO))));

  // R4: zero-divide and overflow never reported together
  a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_divzero && res_ovf));

  // R1: byte-mode normal completion at edge 18
  a_r1_byte_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !wide_r && !res_divzero && !res_ovf) |->
      (tm_count == CNT_W'(LAT_B_RUN)));
endmodule

// File: tb/sdiv_top_tb_top.sv
module sdiv_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 19;

  typedef struct packed {
    logic        wide;
    logic [31:0] dvd;
    logic [15:0] dvs;
    logic        dz;
    logic        ovf;
    logic [5:0]  lat;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'hABCD_0064, 16'h5507, 1'b0, 1'b0, 6'd18},
    '{1'b0, 32'h0000_FF9C, 16'h0007, 1'b0, 1'b0, 6'd18},
    '{1'b0, 32'h0000_0064, 16'h00F9, 1'b0, 1'b0, 6'd18},
    '{1'b0, 32'h0000_FF9C, 16'h00F9, 1'b0, 1'b0, 6'd18},
    '{1'b0, 32'h0000_03E8, 16'h0080, 1'b0, 1'b0, 6'd18},
    '{1'b0, 32'h0000_04D2, 16'h0000, 1'b1, 1'b0, 6'd3},
    '{1'b0, 32'h0000_1000, 16'h0010, 1'b0, 1'b1, 6'd8},
    '{1'b0, 32'h0000_0FFF, 16'h0010, 1'b0, 1'b1, 6'd18},
    '{1'b0, 32'h0000_F800, 16'h0010, 1'b0, 1'b0, 6'd18},
    '{1'b0, 32'h0000_0800, 16'h0010, 1'b0, 1'b1, 6'd18},
    '{1'b0, 32'h0000_8000, 16'h00FF, 1'b0, 1'b1, 6'd8},
    '{1'b1, 32'h000F_4240, 16'h012C, 1'b0, 1'b0, 6'd30},
    '{1'b1, 32'hFFF0_BDC0, 16'h012C, 1'b0, 1'b0, 6'd31},
    '{1'b1, 32'h1234_5678, 16'h8000, 1'b0, 1'b0, 6'd30},
    '{1'b1, 32'h8765_4321, 16'h0000, 1'b1, 1'b0, 6'd4},
    '{1'b1, 32'h0010_0000, 16'h0010, 1'b0, 1'b1, 6'd10},
    '{1'b1, 32'hFFF0_0000, 16'h0010, 1'b0, 1'b1, 6'd11},
    '{1'b1, 32'h0008_0000, 16'h0010, 1'b0, 1'b1, 6'd29},
    '{1'b1, 32'hFFF8_0000, 16'h0010, 1'b0, 1'b0, 6'd31}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_wide = 1'b0;
  logic [31:0] req_dividend = '0;
  logic [15:0] req_divisor = '0;
  logic        req_ready, busy, res_valid, res_divzero, res_ovf;
  logic [15:0] res_quot, res_rem;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdiv_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_wide(req_wide), .req_dividend(req_dividend), .req_divisor(req_divisor),
    .busy(busy), .res_valid(res_valid), .res_quot(res_quot), .res_rem(res_rem),
    .res_divzero(res_divzero), .res_ovf(res_ovf)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input logic w, input logic [31:0] d, input logic [15:0] v,
                        output int lat);
    @(negedge clk);
    req_wide = w; req_dividend = d; req_divisor = v; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!res_valid && lat < 63) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic [15:0] hold_q, hold_r;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(busy == 1'b0, "R10", "busy", 32'(busy), 0);
    chk(req_ready == 1'b1, "R10", "ready", 32'(req_ready), 1);
    chk(res_valid == 1'b0, "R10", "valid", 32'(res_valid), 0);
    chk({res_divzero, res_ovf} == 2'b00, "R10", "flags", 32'({res_divzero, res_ovf}), 0);
    chk(res_quot == 16'h0 && res_rem == 16'h0, "R10", "result", {res_quot, res_rem}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10", "ready after release", 32'(req_ready), 1);

    for (int i = 0; i < NV; i++) begin
      vec_t   t;
      string  tag;
      int     a, b, eq, er;
      logic [15:0] msk, exp_q, exp_r, up, lo;
      t   = VECS[i];
      msk = t.wide ? 16'hFFFF : 16'h00FF;
      up  = t.wide ? t.dvd[31:16] : {8'h00, t.dvd[15:8]};
      lo  = t.wide ? t.dvd[15:0]  : {8'h00, t.dvd[7:0]};
      if (t.dz)                 tag = "R3";
      else if (t.ovf && (t.lat == 8 || t.lat == 10 || t.lat == 11)) tag = "R4";
      else if (t.ovf)           tag = "R5";
      else if (t.wide)          tag = "R2";
      else                      tag = "R1";
      run_op(t.wide, t.dvd, t.dvs, lat);
      chk(lat == int'(t.lat), tag, $sformatf("latency v%0d", i), 32'(lat), 32'(t.lat));
      chk(res_divzero == t.dz, tag, $sformatf("divzero v%0d", i), 32'(res_divzero), 32'(t.dz));
      chk(res_ovf == t.ovf, tag, $sformatf("ovf v%0d", i), 32'(res_ovf), 32'(t.ovf));
      if (t.dz) begin
        chk(res_quot == lo, "R3", $sformatf("quot v%0d", i), 32'(res_quot), 32'(lo));
        chk(res_rem == up, "R3", $sformatf("rem v%0d", i), 32'(res_rem), 32'(up));
      end else if (t.ovf) begin
        chk(res_rem == up, "R6", $sformatf("rem kept v%0d", i), 32'(res_rem), 32'(up));
      end else begin
        a = t.wide ? int'($signed(t.dvd)) : int'($signed(t.dvd[15:0]));
        b = t.wide ? int'($signed(t.dvs)) : int'($signed(t.dvs[7:0]));
        eq = a / b;
        er = a % b;
        exp_q = 16'(eq) & msk;
        exp_r = 16'(er) & msk;
        if (exp_q == 16'h0080 && !t.wide) tag = "R7";
        if (exp_q == 16'h8000 && t.wide)  tag = "R7";
        chk(res_quot == exp_q, tag, $sformatf("quot v%0d", i), 32'(res_quot), 32'(exp_q));
        chk(res_rem == exp_r, tag, $sformatf("rem v%0d", i), 32'(res_rem), 32'(exp_r));
      end
      @(negedge clk);
      chk(res_valid == 1'b0, "R8", $sformatf("pulse width v%0d", i), 32'(res_valid), 0);
    end

    // R9: requests while busy are ignored
    @(negedge clk);
    req_wide = 1'b0; req_dividend = 32'h0000_0064; req_divisor = 16'h0007; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(req_ready == 1'b0, "R9", "ready while busy", 32'(req_ready), 0);
    req_wide = 1'b1; req_dividend = 32'h000F_4240; req_divisor = 16'h012C;
    lat = 1;
    while (!res_valid && lat < 63) begin
      @(negedge clk);
      lat++;
      if (lat == 6) req_valid = 1'b0;
    end
    chk(lat == 18, "R9", "first op latency", 32'(lat), 18);
    chk(res_quot == 16'h000E, "R9", "first op quot", 32'(res_quot), 32'h0E);
    chk(res_rem == 16'h0002, "R9", "first op rem", 32'(res_rem), 32'h02);

    // R8: result holds until next acceptance
    hold_q = res_quot; hold_r = res_rem;
    repeat (5) @(negedge clk);
    chk(busy == 1'b0, "R8", "idle after done", 32'(busy), 0);
    chk(res_quot == hold_q && res_rem == hold_r, "R8", "result held",
        {res_quot, res_rem}, {hold_q, hold_r});
    chk(res_valid == 1'b0, "R8", "no extra pulse", 32'(res_valid), 0);

    // R3: flag stays until next acceptance, then clears
    run_op(1'b0, 32'h0000_1234, 16'h0000, lat);
    repeat (4) @(negedge clk);
    chk(res_divzero == 1'b1, "R3", "divzero held", 32'(res_divzero), 1);
    run_op(1'b0, 32'h0000_0064, 16'h0007, lat);
    chk(res_divzero == 1'b0, "R3", "divzero cleared", 32'(res_divzero), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule